// File: doc/BRIEF.md
# Timer Prescaler with Held Reset

This block produces the count enable for an 8-bit timer/counter. A free-running 10-bit divider supplies taps at divide-by-8, 64, 256 and 1024. A 3-bit select picks which source drives the one-cycle enable pulse:

- one of those taps,
- the system clock itself,
- nothing, or
- a rising or falling edge on an external clock pin, sampled through a two-flop synchronizer.

External edges go past the divider and are never divided.

An 8-bit control byte is written and read through a simple register port. It holds two bits:

- A divider-clear bit. Setting it clears the divider and blocks every enable. It normally drops back to zero by itself one cycle later.
- A hold bit. While the hold bit is set, the divider-clear bit keeps the value written to it. Software can therefore freeze the timer, set it up, and then release it by writing the hold bit to zero.

Top module: `pscl_top`

## Requirements
- R1: The control byte resets to 0x00. Bit 7 is the hold bit and bit 0 is the divider-clear bit, and both can be written. Bits 6 to 1 always read zero. `regRdData` shows the stored byte.
- R2: With bit 7 at zero, writing a one to bit 0 makes bit 0 read one in the cycle after the write. Bit 0 then reads zero in the cycle after that.
- R3: With bit 7 at one, bit 0 keeps its written value on every cycle until the next write.
- R4: Writing a byte with bit 7 at zero and bit 0 at zero makes the byte read 0x00 in the next cycle, and the selected source starts producing enables.
- R5: While bit 0 reads one, `countEn` is zero for every select value and for every external edge, and the divider is held at zero.
- R6: Select 0 gives no enables. Select 1 gives an enable on every cycle in which bit 0 is zero.
- R7: Selects 2, 3, 4 and 5 divide by 8, 64, 256 and 1024. Each enable lasts one cycle. The first enable comes in released cycle N-1, counting from 0 as the first cycle with bit 0 at zero, and the next ones follow every N cycles.
- R8: Select 7 counts rising edges of `extClkPin` and select 6 counts falling edges. A pin change driven between two clock edges gives an enable in the cycle after the second following rising clock edge, and that enable lasts exactly one cycle.
- R9: A pin pulse that spans no rising clock edge produces no enable.
- R10: Under selects 6 and 7, every qualifying edge with half periods of at least two cycles gives exactly one enable. External edges are not divided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Control byte write strobe |
| regWrData | input | 8 | Control byte write value |
| regRdData | output | 8 | Control byte read value |
| clkSel | input | 3 | Count source select (0 stop, 1 system clock, 2..5 divided, 6 falling edge, 7 rising edge) |
| extClkPin | input | 1 | External clock pin, asynchronous |
| countEn | output | 1 | Single-cycle count enable to the timer |

## Verification
The checker watches several properties on every cycle:

- the reserved bits stay at zero;
- the clear bit drops by itself when the hold bit is zero, and is kept when it is one;
- a write of zero clears the byte;
- no enable appears while the clear bit is set or the select is 0;
- enables under the divided and external selects never last two cycles in a row.

The bench scenarios cover what depends on timing and on stimulus:

- the divide ratios, and the position of the first tick after release;
- the exact synchronizer latency from a pin change;
- whether rising or falling edges are counted;
- that a glitch faster than the sampling is dropped;
- one enable per external edge.

// File: rtl/pscl_pkg.sv
`timescale 1ns/1ps
package pscl_pkg;

  localparam int REG_W    = 8;
  localparam int HOLD_BIT = 7;
  localparam int CLR_BIT  = 0;
  localparam int SEL_W    = 3;
  localparam int NUM_TAPS = 4;

  typedef enum logic [SEL_W-1:0] {
    SRC_STOP   = 3'd0,
    SRC_SYSCLK = 3'd1,
    SRC_DIV_A  = 3'd2,
    SRC_DIV_B  = 3'd3,
    SRC_DIV_C  = 3'd4,
    SRC_DIV_D  = 3'd5,
    SRC_EXT_FALL = 3'd6,
    SRC_EXT_RISE = 3'd7
  } srcSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic dividerClear;   // clear divider to zero this cycle
    logic enableBlock;    // suppress every count enable this cycle
  } ctrlStrobe_t;

endpackage

// File: rtl/pscl_ctrl.sv
`timescale 1ns/1ps
module pscl_ctrl
  import pscl_pkg::*;
#(
  parameter int HOLD_POS = HOLD_BIT,
  parameter int CLR_POS  = CLR_BIT
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output ctrlStrobe_t      strobe
);

  localparam logic [REG_W-1:0] WR_MASK = (REG_W'(1) << HOLD_POS) | (REG_W'(1) << CLR_POS);

  logic [REG_W-1:0] ctrlReg;
  logic             holdOn;
  logic             clrOn;

  assign holdOn = ctrlReg[HOLD_POS];
  assign clrOn  = ctrlReg[CLR_POS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (regWrEn) begin
      ctrlReg <= regWrData & WR_MASK;
    end else if (!holdOn && clrOn) begin
      // self-clearing when not held
      ctrlReg[CLR_POS] <= 1'b0;
    end
  end

  assign regRdData           = ctrlReg;
  assign strobe.dividerClear = clrOn;
  assign strobe.enableBlock  = clrOn;

endmodule

// File: rtl/pscl_datapath.sv
`timescale 1ns/1ps
module pscl_datapath
  import pscl_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2,
  parameter int TAP_LOG [NUM_TAPS] = '{3, 6, 8, 10}
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             extClkPin,
  output logic             countEn
);

  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CNT_W-1:0]    divCnt;
  logic [NUM_TAPS-1:0] tapTick;
  logic [CHAIN_W-1:0]  syncChain;
  logic                syncNow;
  logic                syncPrev;
  logic                extRise;
  logic                extFall;
  logic                rawEn;

  // free-running divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    divCnt <= '0;
    else if (strobe.dividerClear) divCnt <= '0;
    else                          divCnt <= divCnt + 1'b1;
  end

  // one comparator per tap: all bits below the tap are ones
  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    if (TAP_LOG[t] > CNT_W || TAP_LOG[t] < 1) begin : g_bad
      initial $error("tap %0d out of divider range", t);
      assign tapTick[t] = 1'b0;
    end else begin : g_ok
      assign tapTick[t] = &divCnt[TAP_LOG[t]-1:0];
    end
  end

  // synchronizer plus one comparison stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[CHAIN_W-2:0], extClkPin};
  end

  assign syncNow  = syncChain[SYNC_STAGES-1];
  assign syncPrev = syncChain[SYNC_STAGES];
  assign extRise  = syncNow & ~syncPrev;
  assign extFall  = ~syncNow & syncPrev;

  always_comb begin
    unique case (srcSel_e'(clkSel))
      SRC_STOP:     rawEn = 1'b0;
      SRC_SYSCLK:   rawEn = 1'b1;
      SRC_DIV_A:    rawEn = tapTick[0];
      SRC_DIV_B:    rawEn = tapTick[1];
      SRC_DIV_C:    rawEn = tapTick[2];
      SRC_DIV_D:    rawEn = tapTick[3];
      SRC_EXT_FALL: rawEn = extFall;
      SRC_EXT_RISE: rawEn = extRise;
      default:      rawEn = 1'b0;
    endcase
  end

  assign countEn = rawEn & ~strobe.enableBlock;

endmodule

// File: rtl/pscl_top.sv
`timescale 1ns/1ps
module pscl_top
  import pscl_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             extClkPin,
  output logic             countEn
);

  ctrlStrobe_t strobe;

  pscl_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .strobe    (strobe)
  );

  pscl_datapath #(
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .clkSel    (clkSel),
    .extClkPin (extClkPin),
    .countEn   (countEn)
  );

endmodule

// File: rtl/pscl_checker.sv
`timescale 1ns/1ps
module pscl_checker (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic [2:0] clkSel,
  input logic       countEn
);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[6:1] == 6'd0); // R1

  AST_CLR_SELF_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && !regRdData[7] && regRdData[0]) |=> !regRdData[0]); // R2

  AST_CLR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && regRdData[7] && regRdData[0]) |=> regRdData[0]); // R3

  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regWrData[7] && !regWrData[0]) |=> (regRdData == 8'd0)); // R4

  AST_NO_EN_IN_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[0] |-> !countEn); // R5

  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == 3'd0) |-> !countEn); // R6

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && clkSel >= 3'd2) |=> !(countEn && clkSel == $past(clkSel))); // R7

endmodule

bind pscl_top pscl_checker i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .clkSel    (clkSel),
  .countEn   (countEn)
);

// File: tb/test_pscl_top.sv
`timescale 1ns/1ps
module test_pscl_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic [2:0] clkSel = 3'd0;
  logic       extClkPin = 1'b0;
  logic       countEn;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pscl_top i_pscl_top (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .clkSel    (clkSel),
    .extClkPin (extClkPin),
    .countEn   (countEn)
  );

  // vector: select, window length, expected enables from release
  typedef struct packed {
    logic [2:0]  sel;
    logic [15:0] window;
    logic [15:0] expect_n;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'd0, 16'd50,   16'd0},   // R6 stop
    '{3'd1, 16'd40,   16'd40},  // R6 every cycle
    '{3'd2, 16'd40,   16'd5},   // R7 /8
    '{3'd3, 16'd200,  16'd3},   // R7 /64
    '{3'd4, 16'd600,  16'd2},   // R7 /256
    '{3'd5, 16'd2100, 16'd2}    // R7 /1024
  };

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // write spans one rising edge, ends at a falling edge
  task automatic regWrite(input logic [7:0] d);
    regWrEn = 1'b1;
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    regWrData = 8'd0;
  endtask

  task automatic countWindow(input int w, output int n);
    n = 0;
    repeat (w) begin
      if (countEn) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset byte", regRdData, 8'h00);
    check("R1 reset enable", countEn, 0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: hold, release, count
    for (int v = 0; v < 6; v++) begin
      clkSel = VECS[v].sel;
      regWrite(8'h81);
      check("R3 hold byte", regRdData, 8'h81);
      regWrite(8'h00);
      countWindow(int'(VECS[v].window), n);
      check(VECS[v].sel >= 3'd2 ? "R7 divided count" : "R6 source count", n, int'(VECS[v].expect_n));
    end

    // R1 reserved bits
    regWrite(8'hFF);
    check("R1 reserved bits read zero", regRdData, 8'h81);
    regWrite(8'h00);

    // R2 self clear
    regWrite(8'h01);
    check("R2 clear bit set after write", regRdData, 8'h01);
    @(negedge clk);
    check("R2 clear bit dropped", regRdData, 8'h00);

    // R3 and R5 held with sysclk select
    clkSel = 3'd1;
    regWrite(8'h81);
    countWindow(10, n);
    check("R3 clear bit still held", regRdData, 8'h81);
    check("R5 no enable while held", n, 0);
    // R5 external edge while held
    clkSel = 3'd7;
    extClkPin = 1'b1;
    countWindow(6, n);
    check("R5 no external enable while held", n, 0);
    extClkPin = 1'b0;
    countWindow(4, n);

    // R4 release
    clkSel = 3'd1;
    regWrite(8'h00);
    check("R4 byte cleared", regRdData, 8'h00);
    check("R4 counting starts", countEn, 1);

    // R8 rising edge latency
    clkSel = 3'd7;
    countWindow(4, n);
    extClkPin = 1'b1;
    @(negedge clk);
    check("R8 no enable after one edge", countEn, 0);
    @(negedge clk);
    check("R8 rise enable after two edges", countEn, 1);
    @(negedge clk);
    check("R8 rise enable single cycle", countEn, 0);
    // falling edge ignored under rising select
    extClkPin = 1'b0;
    countWindow(5, n);
    check("R8 fall ignored under rise select", n, 0);

    // R8 falling select
    clkSel = 3'd6;
    extClkPin = 1'b1;
    countWindow(5, n);
    check("R8 rise ignored under fall select", n, 0);
    extClkPin = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 fall enable after two edges", countEn, 1);
    @(negedge clk);
    check("R8 fall enable single cycle", countEn, 0);

    // R9 glitch narrower than a clock, between rising edges
    clkSel = 3'd7;
    countWindow(3, n);
    extClkPin = 1'b1;
    #5;
    extClkPin = 1'b0;
    @(negedge clk);
    countWindow(6, n);
    check("R9 fast glitch gives no enable", n, 0);

    // R10 one enable per edge, undivided
    begin
      int total = 0;
      for (int k = 0; k < 10; k++) begin
        extClkPin = 1'b1;
        countWindow(2, n);
        total += n;
        extClkPin = 1'b0;
        countWindow(2, n);
        total += n;
      end
      countWindow(4, n);
      total += n;
      check("R10 one enable per rising edge", total, 10);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule